// File: doc/BRIEF.md
# Sector Erase Sequencer for a Flash on the Low Pin Count Bus

This block is host-side logic that erases one sector of a flash device on the Low Pin Count (LPC) bus. A one-clock start request carries the target sector address, a completion-detect mode and a limit on status reads. The block then drives six memory-write byte cycles on the 4-bit multiplexed bus. Together these form the unlock-and-erase command. It then issues memory-read cycles at the sector address until the device reports that its internal erase has finished.

Two detection modes are available. In toggle mode, the block compares bit 6 of each status byte with bit 6 of the byte before it, and the device is idle once that bit stops changing. In data mode, the block waits for bit 7 to read back as 1, which is the erased value. A target that never returns the ready sync nibble aborts the transaction. A device that is still busy after the allowed number of reads also ends the run. Each of these faults reports its own error code. The upper half of every unlock address comes from a parameter, so the cycles fall inside the window where the flash is mapped.

The sequencer has eight states. `SQ_IDLE` moves to `SQ_WR_ISSUE` on start. `SQ_WR_ISSUE` moves to `SQ_WR_WAIT`. `SQ_WR_WAIT` goes back to `SQ_WR_ISSUE` for the next command, or moves to `SQ_RD_ISSUE` after the sixth command. `SQ_RD_ISSUE` moves to `SQ_RD_WAIT`, which moves to `SQ_JUDGE`. `SQ_JUDGE` moves to `SQ_DONE` when the erase is complete, to `SQ_FAIL` when the read limit is reached, and otherwise back to `SQ_RD_ISSUE`. A sync fault in either wait state moves to `SQ_FAIL`. `SQ_DONE` and `SQ_FAIL` both return to `SQ_IDLE`.

The bus cycle engine has thirteen states. `CY_IDLE` moves to `CY_START`, then `CY_CTYPE`, then `CY_ADDR`, which lasts eight clocks. A write continues through `CY_WDAT0` and `CY_WDAT1` to `CY_HTAR1`. A read goes from `CY_ADDR` straight to `CY_HTAR1`. Both then pass through `CY_HTAR2` to `CY_SYNC`. In `CY_SYNC`, a read moves to `CY_RDAT0` and then `CY_RDAT1`, and a write moves straight to `CY_PTAR1`. Both finish through `CY_PTAR1` and `CY_PTAR2` back to `CY_IDLE`. A sync timeout returns `CY_SYNC` directly to `CY_IDLE`.

Top module: `lpc_sector_eraser`

## Requirements
- R1: After reset, frame_n_o is 1, lad_oe_o is 0, busy_o, done_o and err_o are 0, and err_code_o is 0.
- R2: A start_i pulse while busy_o is 0 latches sector_i, poll_mode_i and max_polls_i, and busy_o is 1 from the next clock. A start_i pulse while busy_o is 1 has no effect on the running erase.
- R3: A write cycle is driven as follows:
  - frame_n_o is low for exactly one clock, during which lad_o is 0000b.
  - The cycle-type nibble is 0110b.
  - Eight address nibbles follow, most significant first.
  - Two data nibbles follow, low nibble first.
  - One clock of 1111b is driven.
  - The bus is then released until a 0000b sync nibble is sampled.
  - Two turnaround clocks follow.
- R4: A read cycle uses the same start nibble and address order with cycle-type nibble 0100b. After the address, one clock of 1111b is driven, then a float clock, then the wait for sync 0000b. The target then supplies two data nibbles, low nibble first, followed by two turnaround clocks.
- R5: The six writes are, in order: UNLOCK_HI:5555h/AAh, UNLOCK_HI:2AAAh/55h, UNLOCK_HI:5555h/80h, UNLOCK_HI:5555h/AAh, UNLOCK_HI:2AAAh/55h, and then sector address/30h. UNLOCK_HI is the upper 16 address bits.
- R6: lad_oe_o is 0 while idle, in the float turnaround clock, during the sync wait, while the target returns read data, and in the closing turnaround.
- R7: Every status read is addressed to the latched sector address.
- R8: With poll_mode_i = 0 (toggle mode), the erase is complete on the first read whose bit 6 equals bit 6 of the previous read. This needs at least two reads.
- R9: With poll_mode_i = 1 (data mode), the erase is complete on the first read whose bit 7 is 1.
- R10: If the erase is not complete when the number of status reads reaches max_polls_i, the run ends with err_code_o = 2. A value of 0 acts like 1. A read that completes the erase wins over the limit.
- R11: If no 0000b sync nibble is sampled within SYNC_WAIT clocks of the sync wait, the cycle is abandoned, the bus is released, no further cycle starts, and the run ends with err_code_o = 1.
- R12: done_o (success, err_code_o = 0) or err_o (failure) pulses for exactly one clock, never both at once, and busy_o is 0 on the following clock. err_code_o holds until the next accepted start, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock erase request |
| sector_i | input | 32 | Full address of the sector to erase |
| poll_mode_i | input | 1 | 0 = toggle-bit detection, 1 = data-bit detection |
| max_polls_i | input | POLL_W | Maximum number of status reads |
| lad_i | input | 4 | Nibble sampled from the shared bus |
| lad_o | output | 4 | Nibble driven onto the shared bus |
| lad_oe_o | output | 1 | Drive enable for lad_o |
| frame_n_o | output | 1 | Active-low cycle-start marker |
| busy_o | output | 1 | An erase transaction is running |
| done_o | output | 1 | One-clock pulse on successful completion |
| err_o | output | 1 | One-clock pulse on failure |
| err_code_o | output | 2 | 0 = none, 1 = sync timeout, 2 = read limit reached |

## Verification
The main function is driven by a target model that answers each read with a status byte. The status stays busy for a chosen number of reads and then returns FFh. In toggle mode, busy lengths of zero, two, three and six reads separate several cases:
- Two equal bits seen on the first steady read.
- A final busy read whose bit 6 already equals the steady value.
- A limit reached while the bit still alternates.

In data mode, zero, four and nine busy reads separate the following cases:
- Immediate completion.
- Completion in the middle of the run.
- A timeout that lands exactly on the limit.

A limit of 0 or 1 checks the lower boundary. A sync delay of up to three clocks checks the sync wait, and a target that never sends sync separates the abort path from the timeout path.

// File: rtl/lpc_erase_pkg.sv
package lpc_erase_pkg;

    typedef enum logic [3:0] {
        CY_IDLE, CY_START, CY_CTYPE, CY_ADDR, CY_WDAT0, CY_WDAT1,
        CY_HTAR1, CY_HTAR2, CY_SYNC, CY_RDAT0, CY_RDAT1, CY_PTAR1, CY_PTAR2
    } cyc_state_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_WR_ISSUE, SQ_WR_WAIT, SQ_RD_ISSUE, SQ_RD_WAIT,
        SQ_JUDGE, SQ_DONE, SQ_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SYNC = 2'd1,
        ERR_POLL = 2'd2
    } err_code_t;

    localparam logic [3:0] NIB_START   = 4'h0;
    localparam logic [3:0] NIB_MEM_RD  = 4'h4;
    localparam logic [3:0] NIB_MEM_WR  = 4'h6;
    localparam logic [3:0] NIB_TAR     = 4'hF;
    localparam logic [3:0] NIB_SYNC_OK = 4'h0;

    localparam int CMD_COUNT = 6;
    localparam int CMD_IW    = $clog2(CMD_COUNT);

    // Low 16 bits of the address used by each unlock step
    function automatic logic [15:0] cmd_low_addr(input logic [CMD_IW-1:0] idx);
        return (idx == CMD_IW'(1) || idx == CMD_IW'(4)) ? 16'h2AAA : 16'h5555;
    endfunction

    // Byte written by each step of the erase command
    function automatic logic [7:0] cmd_data(input logic [CMD_IW-1:0] idx);
        logic [7:0] d;
        unique case (idx)
            CMD_IW'(0), CMD_IW'(3): d = 8'hAA;
            CMD_IW'(1), CMD_IW'(4): d = 8'h55;
            CMD_IW'(2):             d = 8'h80;
            default:                d = 8'h30;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lpc_cycle_engine.sv
module lpc_cycle_engine
    import lpc_erase_pkg::*;
#(
    parameter int SYNC_WAIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        rd_i,
    input  logic [31:0] addr_i,
    input  logic [7:0]  wdata_i,
    input  logic [3:0]  lad_i,
    output logic [3:0]  lad_o,
    output logic        lad_oe_o,
    output logic        frame_n_o,
    output logic        done_o,
    output logic        sync_err_o,
    output logic [7:0]  rdata_o
);

    localparam int SCW = $clog2(SYNC_WAIT + 1);
    localparam logic [SCW-1:0] SYNC_LAST = SCW'(SYNC_WAIT - 1);

    cyc_state_t     state, nxt;
    logic           rd_r;
    logic [31:0]    addr_r;
    logic [7:0]     wdat_r;
    logic [2:0]     nib;
    logic [SCW-1:0] scnt;
    logic [7:0]     rbyte;

    logic sync_seen, sync_expired;
    assign sync_seen    = (lad_i == NIB_SYNC_OK);
    assign sync_expired = !sync_seen && (scnt == SYNC_LAST);

    // State register and cycle datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CY_IDLE;
            rd_r   <= 1'b0;
            addr_r <= '0;
            wdat_r <= '0;
            nib    <= '0;
            scnt   <= '0;
            rbyte  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                CY_IDLE: if (req_i) begin
                    rd_r   <= rd_i;
                    addr_r <= addr_i;
                    wdat_r <= wdata_i;
                    nib    <= 3'd7;
                end
                CY_ADDR:  nib   <= nib - 3'd1;
                CY_HTAR2: scnt  <= '0;
                CY_SYNC:  scnt  <= scnt + SCW'(1);
                CY_RDAT0: rbyte[3:0] <= lad_i;
                CY_RDAT1: rbyte[7:4] <= lad_i;
                default: ;
            endcase
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            CY_IDLE:  if (req_i) nxt = CY_START;
            CY_START: nxt = CY_CTYPE;
            CY_CTYPE: nxt = CY_ADDR;
            CY_ADDR:  if (nib == 3'd0) nxt = rd_r ? CY_HTAR1 : CY_WDAT0;
            CY_WDAT0: nxt = CY_WDAT1;
            CY_WDAT1: nxt = CY_HTAR1;
            CY_HTAR1: nxt = CY_HTAR2;
            CY_HTAR2: nxt = CY_SYNC;
            CY_SYNC: begin
                if (sync_seen)         nxt = rd_r ? CY_RDAT0 : CY_PTAR1;
                else if (sync_expired) nxt = CY_IDLE;
            end
            CY_RDAT0: nxt = CY_RDAT1;
            CY_RDAT1: nxt = CY_PTAR1;
            CY_PTAR1: nxt = CY_PTAR2;
            CY_PTAR2: nxt = CY_IDLE;
            default:  nxt = CY_IDLE;
        endcase
    end

    // Bus outputs
    always_comb begin
        frame_n_o = 1'b1;
        lad_oe_o  = 1'b0;
        lad_o     = NIB_TAR;
        unique case (state)
            CY_START: begin frame_n_o = 1'b0; lad_oe_o = 1'b1; lad_o = NIB_START; end
            CY_CTYPE: begin lad_oe_o = 1'b1; lad_o = rd_r ? NIB_MEM_RD : NIB_MEM_WR; end
            CY_ADDR:  begin lad_oe_o = 1'b1; lad_o = addr_r[{nib, 2'b00} +: 4]; end
            CY_WDAT0: begin lad_oe_o = 1'b1; lad_o = wdat_r[3:0]; end
            CY_WDAT1: begin lad_oe_o = 1'b1; lad_o = wdat_r[7:4]; end
            CY_HTAR1: begin lad_oe_o = 1'b1; lad_o = NIB_TAR; end
            default: ;
        endcase
    end

    assign done_o     = (state == CY_PTAR2);
    assign sync_err_o = (state == CY_SYNC) && sync_expired;
    assign rdata_o    = rbyte;

endmodule

// File: rtl/lpc_erase_seq.sv
module lpc_erase_seq
    import lpc_erase_pkg::*;
#(
    parameter int          POLL_W    = 16,
    parameter logic [15:0] UNLOCK_HI = 16'hFF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       sector_i,
    input  logic              poll_mode_i,
    input  logic [POLL_W-1:0] max_polls_i,
    input  logic              cyc_done_i,
    input  logic              cyc_sync_err_i,
    input  logic [7:0]        cyc_rdata_i,
    output logic              cyc_req_o,
    output logic              cyc_rd_o,
    output logic [31:0]       cyc_addr_o,
    output logic [7:0]        cyc_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o
);

    localparam logic [CMD_IW-1:0] CMD_LAST = CMD_IW'(CMD_COUNT - 1);

    seq_state_t        state, nxt;
    logic [CMD_IW-1:0] idx;
    logic [31:0]       sect_r;
    logic              mode_r;
    logic [POLL_W-1:0] max_r;
    logic [POLL_W-1:0] polls;
    logic              prev6;
    logic              have_prev;
    err_code_t         code_r;

    logic complete, limit_hit;
    assign complete  = mode_r ? cyc_rdata_i[7]
                              : (have_prev && (cyc_rdata_i[6] == prev6));
    assign limit_hit = (polls >= max_r);

    // State register and sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            sect_r    <= '0;
            mode_r    <= 1'b0;
            max_r     <= '0;
            polls     <= '0;
            prev6     <= 1'b0;
            have_prev <= 1'b0;
            code_r    <= ERR_NONE;
        end else begin
            state <= nxt;
            unique case (state)
                SQ_IDLE: if (start_i) begin
                    sect_r    <= sector_i;
                    mode_r    <= poll_mode_i;
                    max_r     <= max_polls_i;
                    idx       <= '0;
                    polls     <= '0;
                    have_prev <= 1'b0;
                    code_r    <= ERR_NONE;
                end
                SQ_WR_WAIT: begin
                    if (cyc_sync_err_i)  code_r <= ERR_SYNC;
                    else if (cyc_done_i) idx    <= idx + CMD_IW'(1);
                end
                SQ_RD_WAIT: begin
                    if (cyc_sync_err_i)  code_r <= ERR_SYNC;
                    else if (cyc_done_i) polls  <= polls + POLL_W'(1);
                end
                SQ_JUDGE: begin
                    prev6     <= cyc_rdata_i[6];
                    have_prev <= 1'b1;
                    if (!complete && limit_hit) code_r <= ERR_POLL;
                end
                default: ;
            endcase
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:     if (start_i) nxt = SQ_WR_ISSUE;
            SQ_WR_ISSUE: nxt = SQ_WR_WAIT;
            SQ_WR_WAIT: begin
                if (cyc_sync_err_i)  nxt = SQ_FAIL;
                else if (cyc_done_i) nxt = (idx == CMD_LAST) ? SQ_RD_ISSUE : SQ_WR_ISSUE;
            end
            SQ_RD_ISSUE: nxt = SQ_RD_WAIT;
            SQ_RD_WAIT: begin
                if (cyc_sync_err_i)  nxt = SQ_FAIL;
                else if (cyc_done_i) nxt = SQ_JUDGE;
            end
            SQ_JUDGE: begin
                if (complete)       nxt = SQ_DONE;
                else if (limit_hit) nxt = SQ_FAIL;
                else                nxt = SQ_RD_ISSUE;
            end
            SQ_DONE: nxt = SQ_IDLE;
            SQ_FAIL: nxt = SQ_IDLE;
            default: nxt = SQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cyc_req_o   = 1'b0;
        cyc_rd_o    = 1'b0;
        cyc_addr_o  = sect_r;
        cyc_wdata_o = cmd_data(idx);
        unique case (state)
            SQ_WR_ISSUE: begin
                cyc_req_o  = 1'b1;
                cyc_addr_o = (idx == CMD_LAST) ? sect_r : {UNLOCK_HI, cmd_low_addr(idx)};
            end
            SQ_RD_ISSUE: begin
                cyc_req_o = 1'b1;
                cyc_rd_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o     = (state != SQ_IDLE);
    assign done_o     = (state == SQ_DONE);
    assign err_o      = (state == SQ_FAIL);
    assign err_code_o = code_r;

endmodule

// File: rtl/lpc_sector_eraser.sv
module lpc_sector_eraser
    import lpc_erase_pkg::*;
#(
    parameter int          POLL_W    = 16,
    parameter int          SYNC_WAIT = 8,
    parameter logic [15:0] UNLOCK_HI = 16'hFF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       sector_i,
    input  logic              poll_mode_i,
    input  logic [POLL_W-1:0] max_polls_i,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe_o,
    output logic              frame_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o
);

    logic        req, rd, cdone, serr;
    logic [31:0] addr;
    logic [7:0]  wdata, rdata;

    lpc_erase_seq #(
        .POLL_W    (POLL_W),
        .UNLOCK_HI (UNLOCK_HI)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .sector_i       (sector_i),
        .poll_mode_i    (poll_mode_i),
        .max_polls_i    (max_polls_i),
        .cyc_done_i     (cdone),
        .cyc_sync_err_i (serr),
        .cyc_rdata_i    (rdata),
        .cyc_req_o      (req),
        .cyc_rd_o       (rd),
        .cyc_addr_o     (addr),
        .cyc_wdata_o    (wdata),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .err_code_o     (err_code_o)
    );

    lpc_cycle_engine #(
        .SYNC_WAIT (SYNC_WAIT)
    ) u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .rd_i       (rd),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .lad_i      (lad_i),
        .lad_o      (lad_o),
        .lad_oe_o   (lad_oe_o),
        .frame_n_o  (frame_n_o),
        .done_o     (cdone),
        .sync_err_o (serr),
        .rdata_o    (rdata)
    );

endmodule

// File: rtl/lpc_sector_eraser_chk.sv
module lpc_sector_eraser_chk #(
    parameter int POLL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [POLL_W-1:0] max_polls_i,
    input logic [3:0]        lad_o,
    input logic              lad_oe_o,
    input logic              frame_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [1:0]        err_code_o
);

    assert_start_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |-> (lad_oe_o && lad_o == 4'h0));

    assert_frame_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |=> frame_n_o);

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_idle_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!lad_oe_o && frame_n_o));

    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));

    assert_end_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !busy_o);

    assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_code_o));

    assert_fail_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o == 2'd1 || err_code_o == 2'd2));

    assert_ok_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_code_o == 2'd0));

    logic unused_max;
    assign unused_max = ^max_polls_i;

endmodule

bind lpc_sector_eraser lpc_sector_eraser_chk #(.POLL_W(POLL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .max_polls_i (max_polls_i),
    .lad_o       (lad_o),
    .lad_oe_o    (lad_oe_o),
    .frame_n_o   (frame_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/tb_lpc_sector_eraser.sv
`timescale 1ns/1ps
module tb_lpc_sector_eraser;

    localparam logic [15:0] HI = 16'hFFBC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] sector_i = '0;
    logic        poll_mode_i = 1'b0;
    logic [15:0] max_polls_i = '0;
    logic [3:0]  lad_i = 4'hF;
    logic [3:0]  lad_o;
    logic        lad_oe_o, frame_n_o, busy_o, done_o, err_o;
    logic [1:0]  err_code_o;

    always #2.5 clk = ~clk;

    lpc_sector_eraser #(.POLL_W(16), .SYNC_WAIT(8), .UNLOCK_HI(HI)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
        .poll_mode_i(poll_mode_i), .max_polls_i(max_polls_i), .lad_i(lad_i),
        .lad_o(lad_o), .lad_oe_o(lad_oe_o), .frame_n_o(frame_n_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    int nvec = 0, nfail = 0;
    bit summary_done = 0;

    // ---------------- target model ----------------
    int          cfg_busy = 0, cfg_delay = 0;
    bit          no_sync = 0;
    bit          tact = 0, trd = 0;
    int          tph = 0, tmode = 0, twait = 0;
    logic [31:0] taddr = '0;
    logic [7:0]  tdat = '0, tresp = '0;
    int          busy_left = 0;
    bit          tog = 0;
    int          wr_n = 0, rd_n = 0, starts = 0, float_bad = 0, type_bad = 0;
    logic [31:0] wr_a [0:7];
    logic [7:0]  wr_d [0:7];
    logic [31:0] last_rd = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            tact = 0; tmode = 0; lad_i = 4'hF;
        end else begin
            if (!frame_n_o) begin
                tact = 1; tph = 0; tmode = 0; twait = 0; trd = 0; starts++;
            end else if (tact) tph++;
            lad_i = 4'hF;
            if (tact) begin
                if (tph == 1) begin
                    trd = (lad_o == 4'h4);
                    if (lad_o != 4'h4 && lad_o != 4'h6) type_bad++;
                end
                if (frame_n_o && lad_oe_o && tph >= (trd ? 11 : 13)) float_bad++;
                if (tph >= 2 && tph <= 9) taddr = {taddr[27:0], lad_o};
                if (!trd && tph == 10) tdat[3:0] = lad_o;
                if (!trd && tph == 11) tdat[7:4] = lad_o;
                if (tmode == 0 && tph == (trd ? 12 : 14)) tmode = 1;
                case (tmode)
                    1: begin
                        if (!no_sync && twait >= cfg_delay) begin
                            lad_i = 4'h0;
                            if (trd) begin
                                if (busy_left > 0) begin
                                    tresp = {1'b0, tog, 6'b0}; tog = ~tog; busy_left--;
                                end else tresp = 8'hFF;
                                rd_n++; last_rd = taddr; tmode = 2;
                            end else begin
                                if (wr_n < 8) begin wr_a[wr_n] = taddr; wr_d[wr_n] = tdat; end
                                wr_n++;
                                if (wr_n == 6 && tdat == 8'h30) begin busy_left = cfg_busy; tog = 0; end
                                tmode = 4;
                            end
                        end else begin
                            lad_i = 4'h6; twait++;
                        end
                    end
                    2: begin lad_i = tresp[3:0]; tmode = 3; end
                    3: begin lad_i = tresp[7:4]; tmode = 4; end
                    default: ;
                endcase
            end else if (lad_oe_o) float_bad++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int i, input logic [31:0] s);
        if (i == 5) return s;
        return {HI, (i == 1 || i == 4) ? 16'h2AAA : 16'h5555};
    endfunction

    function automatic logic [7:0] exp_data(input int i);
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2: return 8'h80;
            default: return 8'h30;
        endcase
    endfunction

    task automatic pulse_start(input logic [31:0] s, input bit m, input logic [15:0] mx);
        @(negedge clk);
        start_i = 1; sector_i = s; poll_mode_i = m; max_polls_i = mx;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 20000; k++) begin
            if (done_o || err_o) break;
            @(negedge clk);
        end
    endtask

    task automatic check_writes(input logic [31:0] s);
        bit ok = (wr_n == 6);
        int bad = -1;
        for (int i = 0; i < 6; i++)
            if (ok && (wr_a[i] !== exp_addr(i, s) || wr_d[i] !== exp_data(i))) begin
                ok = 0; if (bad < 0) bad = i;
            end
        // R5 / R3: six writes, addresses MSB first and data low nibble first
        if (bad >= 0)
            chk(0, "R5", "write step", {wr_a[bad], wr_d[bad]}, {exp_addr(bad, s), exp_data(bad)});
        else
            chk(ok, "R5", "write count", wr_n, 6);
    endtask

    // ---------------- vectors ----------------
    typedef struct packed {
        logic [31:0] sect;
        logic        mode;
        logic [7:0]  busy;
        logic [15:0] maxp;
        logic [1:0]  dly;
        logic [1:0]  code;
        logic [7:0]  nrd;
    } vec_t;

    localparam vec_t VT [0:8] = '{
        '{32'hFFB0_1000, 1'b0, 8'd0, 16'd10, 2'd0, 2'd0, 8'd2},
        '{32'hFFB3_7000, 1'b0, 8'd3, 16'd10, 2'd1, 2'd0, 8'd5},
        '{32'hFFB5_2000, 1'b0, 8'd6, 16'd4,  2'd2, 2'd2, 8'd4},
        '{32'hFFB6_0000, 1'b1, 8'd0, 16'd5,  2'd0, 2'd0, 8'd1},
        '{32'hFFB8_F000, 1'b1, 8'd4, 16'd10, 2'd3, 2'd0, 8'd5},
        '{32'hFFBA_4000, 1'b1, 8'd9, 16'd9,  2'd1, 2'd2, 8'd9},
        '{32'hFFB1_E000, 1'b0, 8'd2, 16'd3,  2'd0, 2'd0, 8'd3},
        '{32'hFFB2_3000, 1'b1, 8'd3, 16'd0,  2'd2, 2'd2, 8'd1},
        '{32'hFFB4_5000, 1'b0, 8'd0, 16'd1,  2'd3, 2'd2, 8'd1}
    };

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(frame_n_o == 1 && lad_oe_o == 0, "R1", "bus idle", {frame_n_o, lad_oe_o}, 2'b10);
        chk(!busy_o && !done_o && !err_o && err_code_o == 0, "R1", "status idle",
            {busy_o, done_o, err_o, err_code_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            cfg_busy = int'(VT[v].busy); cfg_delay = int'(VT[v].dly); no_sync = 0;
            wr_n = 0; rd_n = 0;
            pulse_start(VT[v].sect, VT[v].mode, VT[v].maxp);
            chk(busy_o, "R2", "busy after start", busy_o, 1);
            wait_end();
            // R8 / R9 / R10: outcome and read count
            chk(err_code_o == VT[v].code && (done_o == (VT[v].code == 0)),
                VT[v].code == 0 ? (VT[v].mode ? "R9" : "R8") : "R10", "result code",
                err_code_o, VT[v].code);
            chk(rd_n == int'(VT[v].nrd), VT[v].mode ? "R9" : "R8", "status reads",
                rd_n, VT[v].nrd);
            check_writes(VT[v].sect);
            // R7 / R4: read address
            chk(last_rd == VT[v].sect, "R7", "read address", last_rd, VT[v].sect);
            @(negedge clk);
            // R12: single pulse, busy drops
            chk(!done_o && !err_o && !busy_o, "R12", "pulse ends", {done_o, err_o, busy_o}, 0);
            repeat (5) @(negedge clk);
            chk(err_code_o == VT[v].code, "R12", "code held", err_code_o, VT[v].code);
        end

        // R2: start while busy ignored
        cfg_busy = 2; cfg_delay = 0; wr_n = 0; rd_n = 0;
        pulse_start(32'hFFB7_A000, 1'b1, 16'd20);
        repeat (40) @(negedge clk);
        pulse_start(32'hFFB9_0000, 1'b0, 16'd1);
        wait_end();
        chk(done_o && rd_n == 3, "R2", "second start ignored (reads)", rd_n, 3);
        chk(last_rd == 32'hFFB7_A000 && wr_a[5] == 32'hFFB7_A000, "R2",
            "second start ignored (sector)", last_rd, 32'hFFB7_A000);
        repeat (4) @(negedge clk);

        // R11: missing sync aborts
        no_sync = 1; wr_n = 0; rd_n = 0; starts = 0;
        pulse_start(32'hFFBB_0000, 1'b0, 16'd10);
        wait_end();
        chk(err_o && err_code_o == 1, "R11", "sync timeout code", err_code_o, 1);
        repeat (60) @(negedge clk);
        chk(starts == 1 && wr_n == 0, "R11", "no cycle after abort", starts, 1);
        chk(!busy_o && !lad_oe_o, "R11", "bus released", {busy_o, lad_oe_o}, 0);
        no_sync = 0;

        // R12: next start clears the code
        cfg_busy = 0; wr_n = 0; rd_n = 0;
        pulse_start(32'hFFB0_0000, 1'b1, 16'd4);
        chk(err_code_o == 0, "R12", "code cleared on start", err_code_o, 0);
        wait_end();
        chk(done_o && err_code_o == 0, "R12", "success code", err_code_o, 0);
        repeat (4) @(negedge clk);

        // R6 / R3 / R4: float and cycle-type observations over the whole run
        chk(float_bad == 0, "R6", "host drove while it should float", float_bad, 0);
        chk(type_bad == 0, "R3", "cycle type nibble (R4 reads)", type_bad, 0);

        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        end
        $finish;
    end

    initial begin
        #900000;
        if (!summary_done) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule